// File: doc/BRIEF.md
# Registered Integer ALU with Zero and Overflow Flags

This block is the arithmetic and logic stage of a simple load/store integer pipeline. It takes two operand words and a four-bit operation code and produces a result word, a zero flag and a signed-overflow flag. It covers signed and unsigned addition and subtraction, the four bitwise operations (AND, OR, XOR, NOR), and signed and unsigned set-on-less-than.

Subtraction uses the same ripple adder as addition. The B operand is inverted and the carry into bit 0 is forced high. Both comparisons are taken from that shared subtractor. The signed compare uses the sign of the difference corrected by the overflow. The unsigned compare uses the borrow.

The zero flag is the NOR of every result bit. A branch unit can run a subtract and test this flag for equality. The outputs pass through one register stage with a synchronous active-low reset. Sign or zero extension of immediates, shifts, multiply, divide and trapping on overflow are done elsewhere.

Top module: `risc_alu`

## Requirements
- R1: While rst_n is low at a rising clock edge, the outputs become result_o = 0, zero_o = 1 and ovf_o = 0. This holds whatever the operands and operation code are.
- R2: The outputs change only at a rising clock edge. After each edge they show the operation applied to the inputs sampled at that edge, which gives one cycle of latency.
- R3: Code 0010 (signed add) and code 0011 (unsigned add) both give (A + B) mod 2^32. For 0010, ovf_o is 1 exactly when A and B have the same sign and the sum's sign differs from it. For 0011, ovf_o is always 0.
- R4: Code 0110 (signed subtract) and code 0111 (unsigned subtract) both give (A - B) mod 2^32. For 0110, ovf_o is 1 exactly when A and B differ in sign and the difference's sign differs from A's. For 0111, ovf_o is always 0.
- R5: The bitwise operations are 0000 AND, 0001 OR, 1101 XOR and 1100 NOR. Each is applied bit by bit, and ovf_o is 0.
- R6: Code 1010 (signed less-than) returns 1 in bit 0 when A < B as two's-complement numbers and 0 otherwise. Bits 31 to 1 are 0. The answer stays correct when A - B overflows, and ovf_o is 0.
- R7: Code 1011 (unsigned less-than) returns 1 in bit 0 when A < B as unsigned numbers. Bits 31 to 1 are 0, and ovf_o is 0.
- R8: zero_o is 1 exactly when all 32 bits of result_o are 0.
- R9: Every other operation code (0100, 0101, 1000, 1001, 1110, 1111, 0001-free codes not listed above) returns result 0 with ovf_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the outputs are registered on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered flag: result is all zeros |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
Hand-picked vectors probe each edge of the overflow rule:
- the most positive value plus one;
- the most negative value added to itself;
- the most negative value minus one;
- operands of opposite sign that wrap to zero.

These vectors show whether the flag follows the sign rule or the raw carry out, and whether the unsigned codes keep it clear. The less-than pairs cross the sign boundary, so the signed and unsigned orderings give opposite answers. The pair whose subtraction overflows separates a sign-only compare from one corrected by overflow. Random operands across all sixteen codes cover the general cases. They also check that unused codes give zero.

// File: rtl/risc_alu_pkg.sv
// Package: shared operation encoding and widths for the integer ALU.
// Assumes a four-bit operation field decoded by the pipeline's control.
package risc_alu_pkg;

    localparam int ALU_DATA_W = 32;
    localparam int ALU_OP_W   = 4;

    typedef enum logic [ALU_OP_W-1:0] {
        OPC_AND  = 4'b0000,
        OPC_OR   = 4'b0001,
        OPC_ADD  = 4'b0010,
        OPC_ADDU = 4'b0011,
        OPC_SUB  = 4'b0110,
        OPC_SUBU = 4'b0111,
        OPC_SLT  = 4'b1010,
        OPC_SLTU = 4'b1011,
        OPC_NOR  = 4'b1100,
        OPC_XOR  = 4'b1101
    } alu_opc_e;

    typedef enum logic [1:0] {
        BW_AND = 2'b00,
        BW_OR  = 2'b01,
        BW_XOR = 2'b10,
        BW_NOR = 2'b11
    } bw_sel_e;

endpackage

// File: rtl/alu_addsub.sv
// Module: ripple-carry adder/subtractor built from one full-adder cell per bit.
// When sub_i is high, B is inverted bit by bit and the carry into bit 0 is 1,
// which forms A + ~B + 1 = A - B. The carry into the top bit and the carry
// out of it are both exported so that overflow and borrow can be derived.
// Assumes WIDTH >= 2.
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_msb_in_o,
    output logic             c_out_o
);

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] b_eff;

    assign carry[0] = sub_i;

    // One full-adder cell per bit position; the carry ripples upward.
    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        assign b_eff[g]   = b_i[g] ^ sub_i;
        assign sum_o[g]   = a_i[g] ^ b_eff[g] ^ carry[g];
        assign carry[g+1] = (a_i[g] & b_eff[g]) | (a_i[g] & carry[g]) | (b_eff[g] & carry[g]);
    end

    assign c_msb_in_o = carry[WIDTH-1];
    assign c_out_o    = carry[WIDTH];

endmodule

// File: rtl/alu_bitwise.sv
// Module: carry-free bitwise unit; a two-bit select picks AND, OR, XOR or NOR.
// Assumes the select has already been decoded from the operation code.
module alu_bitwise
    import risc_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  bw_sel_e          sel_i,
    output logic [WIDTH-1:0] y_o
);

    // Choose the bitwise function named by the select.
    always_comb begin
        unique case (sel_i)
            BW_AND:  y_o = a_i & b_i;
            BW_OR:   y_o = a_i | b_i;
            BW_XOR:  y_o = a_i ^ b_i;
            BW_NOR:  y_o = ~(a_i | b_i);
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_compare.sv
// Module: less-than decision taken from a subtraction A - B.
// In signed mode the result is the sign of the difference XOR the raw signed
// overflow, which stays correct when the difference wraps. In unsigned mode
// the result is the borrow, i.e. the inverted carry out.
// Assumes its inputs come from a subtractor with carry-in 1.
module alu_compare (
    input  logic diff_sign_i,
    input  logic raw_ovf_i,
    input  logic carry_out_i,
    input  logic unsigned_i,
    output logic less_o
);

    // Pick borrow or corrected sign according to the compare mode.
    always_comb begin
        if (unsigned_i) less_o = ~carry_out_i;
        else            less_o = diff_sign_i ^ raw_ovf_i;
    end

endmodule

// File: rtl/alu_core.sv
// Module: combinational datapath of the ALU. It decodes the operation code,
// drives the shared adder/subtractor, the bitwise unit and the compare unit,
// and selects the result through a multiplexer. It also forms the zero flag
// (NOR of the result) and the overflow flag, which is active only for the
// signed add and subtract codes. Unused codes yield zero.
module alu_core
    import risc_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [ALU_OP_W-1:0] op_i,
    input  logic [WIDTH-1:0]    a_i,
    input  logic [WIDTH-1:0]    b_i,
    output logic [WIDTH-1:0]    result_o,
    output logic                zero_o,
    output logic                ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic             sub_sel;
    logic             cmp_unsigned;
    logic [WIDTH-1:0] as_sum;
    logic             c_msb_in;
    logic             c_out;
    logic             raw_ovf;
    logic [WIDTH-1:0] bw_y;
    bw_sel_e          bw_sel;
    logic             less;

    // Decode which codes use subtraction and which bitwise function to apply.
    always_comb begin
        sub_sel      = 1'b0;
        cmp_unsigned = 1'b0;
        bw_sel       = BW_AND;
        case (op_i)
            OPC_SUB, OPC_SUBU, OPC_SLT: sub_sel = 1'b1;
            OPC_SLTU: begin
                sub_sel      = 1'b1;
                cmp_unsigned = 1'b1;
            end
            OPC_OR:  bw_sel = BW_OR;
            OPC_XOR: bw_sel = BW_XOR;
            OPC_NOR: bw_sel = BW_NOR;
            default: ;
        endcase
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i        (a_i),
        .b_i        (b_i),
        .sub_i      (sub_sel),
        .sum_o      (as_sum),
        .c_msb_in_o (c_msb_in),
        .c_out_o    (c_out)
    );

    assign raw_ovf = c_msb_in ^ c_out;

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (bw_sel),
        .y_o   (bw_y)
    );

    alu_compare u_compare (
        .diff_sign_i (as_sum[MSB]),
        .raw_ovf_i   (raw_ovf),
        .carry_out_i (c_out),
        .unsigned_i  (cmp_unsigned),
        .less_o      (less)
    );

    // Result multiplexer and overflow qualification per operation code.
    always_comb begin
        result_o = '0;
        ovf_o    = 1'b0;
        case (op_i)
            OPC_AND, OPC_OR, OPC_XOR, OPC_NOR: result_o = bw_y;
            OPC_ADD, OPC_SUB: begin
                result_o = as_sum;
                ovf_o    = raw_ovf;
            end
            OPC_ADDU, OPC_SUBU: result_o = as_sum;
            OPC_SLT, OPC_SLTU:  result_o = {{(WIDTH-1){1'b0}}, less};
            default: ;
        endcase
    end

    assign zero_o = ~|result_o;

endmodule

// File: rtl/risc_alu.sv
// Module: top of the integer ALU. It wraps the combinational core with one
// output register stage that has a synchronous active-low reset. The reset
// state is a zero result with zero_o set and ovf_o clear.
// Assumes the inputs are stable around the rising clock edge.
module risc_alu
    import risc_alu_pkg::*;
#(
    parameter int WIDTH = ALU_DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ALU_OP_W-1:0] op_i,
    input  logic [WIDTH-1:0]    a_i,
    input  logic [WIDTH-1:0]    b_i,
    output logic [WIDTH-1:0]    result_o,
    output logic                zero_o,
    output logic                ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] core_result;
    logic             core_zero;
    logic             core_ovf;

    alu_core #(.WIDTH(WIDTH)) u_core (
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .result_o (core_result),
        .zero_o   (core_zero),
        .ovf_o    (core_ovf)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            zero_o   <= 1'b1;
            ovf_o    <= 1'b0;
        end else begin
            result_o <= core_result;
            zero_o   <= core_zero;
            ovf_o    <= core_ovf;
        end
    end

    // R3: adding operands of opposite sign never overflows.
    a_r3_opposite_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OPC_ADD && a_i[MSB] != b_i[MSB]) |=> !ovf_o);

    // R3: unsigned add never flags overflow.
    a_r3_addu_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OPC_ADDU) |=> !ovf_o);

    // R4: unsigned subtract never flags overflow.
    a_r4_subu_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OPC_SUBU) |=> !ovf_o);

    // R4: subtracting operands of equal sign never overflows.
    a_r4_same_sign_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OPC_SUB && a_i[MSB] == b_i[MSB]) |=> !ovf_o);

    // R6: signed less-than clears all upper result bits.
    a_r6_slt_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OPC_SLT) |=> (result_o[MSB:1] == '0 && !ovf_o));

    // R7: unsigned less-than clears all upper result bits.
    a_r7_sltu_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OPC_SLTU) |=> (result_o[MSB:1] == '0 && !ovf_o));

    // R8: the zero flag agrees with the registered result.
    a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == (result_o == '0));

    // R9: codes outside the defined set give zero and no overflow.
    a_r9_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_i inside {OPC_AND, OPC_OR, OPC_ADD, OPC_ADDU, OPC_SUB, OPC_SUBU,
                       OPC_SLT, OPC_SLTU, OPC_NOR, OPC_XOR})
        |=> (result_o == '0 && !ovf_o));

endmodule

// File: tb/risc_alu_test.sv
// Testbench for risc_alu: a vector table walked by one loop, then random
// operands checked against a behavioural reference, then reset and latency.
module risc_alu_test;

    localparam int W = 32;
    localparam int NVEC = 19;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   op_i = '0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic [W-1:0] result_o;
    logic         zero_o;
    logic         ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    risc_alu #(.WIDTH(W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .result_o (result_o),
        .zero_o   (zero_o),
        .ovf_o    (ovf_o)
    );

    // Vector layout: {op[3:0], a[31:0], b[31:0], expected result[31:0], expected ovf}
    localparam logic [100:0] VEC [NVEC] = '{
        {4'b0010, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b1},
        {4'b0011, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0},
        {4'b0010, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1},
        {4'b0010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b0},
        {4'b0110, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1},
        {4'b0111, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0},
        {4'b0110, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b0},
        {4'b0000, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, 1'b0},
        {4'b0001, 32'hF0F0_F0F0, 32'h0F0F_0000, 32'hFFFF_F0F0, 1'b0},
        {4'b1101, 32'hAAAA_AAAA, 32'hFFFF_0000, 32'h5555_AAAA, 1'b0},
        {4'b1100, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0},
        {4'b1100, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0000_0000, 1'b0},
        {4'b1010, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0},
        {4'b1010, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000, 1'b0},
        {4'b1011, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0000, 1'b0},
        {4'b1011, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0},
        {4'b1010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0},
        {4'b0100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
        {4'b1111, 32'h1234_5678, 32'h0000_0001, 32'h0000_0000, 1'b0}
    };

    // Requirement tag that covers a given operation code.
    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'b0010, 4'b0011: return "R3";
            4'b0110, 4'b0111: return "R4";
            4'b0000, 4'b0001, 4'b1100, 4'b1101: return "R5";
            4'b1010: return "R6";
            4'b1011: return "R7";
            default: return "R9";
        endcase
    endfunction

    // Behavioural reference: returns {ovf, result}.
    function automatic logic [W:0] ref_alu(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r;
        logic         v;
        r = '0;
        v = 1'b0;
        case (op)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b1101: r = a ^ b;
            4'b1100: r = ~(a | b);
            4'b0010: begin r = a + b; v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]); end
            4'b0011: r = a + b;
            4'b0110: begin r = a - b; v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]); end
            4'b0111: r = a - b;
            4'b1010: r = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            4'b1011: r = {{(W-1){1'b0}}, (a < b)};
            default: r = '0;
        endcase
        return {v, r};
    endfunction

    task automatic check(input string req, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_i = op;
        a_i  = a;
        b_i  = b;
        @(negedge clk);
    endtask

    task automatic check_all(input logic [3:0] op, input logic [W-1:0] er, input logic ev);
        check(tag_of(op), "result", result_o, er);
        check(tag_of(op), "ovf", {31'b0, ovf_o}, {31'b0, ev});
        check("R8", "zero", {31'b0, zero_o}, {31'b0, (er == '0)});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W:0] ex;
        // R1: reset state with nonzero stimulus applied.
        op_i = 4'b0010; a_i = 32'h7FFF_FFFF; b_i = 32'h1;
        repeat (3) @(negedge clk);
        check("R1", "reset result", result_o, '0);
        check("R1", "reset zero", {31'b0, zero_o}, 32'h1);
        check("R1", "reset ovf", {31'b0, ovf_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed vector table.
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][100:97], VEC[i][96:65], VEC[i][64:33]);
            check_all(VEC[i][100:97], VEC[i][32:1], VEC[i][0]);
        end

        // Random operands across all codes, with biased corner operands.
        for (int i = 0; i < 400; i++) begin
            logic [3:0]   op;
            logic [W-1:0] a;
            logic [W-1:0] b;
            op = 4'(i % 16);
            a  = (i % 7 == 0) ? 32'h8000_0000 : $urandom;
            b  = (i % 11 == 0) ? 32'h7FFF_FFFF : $urandom;
            apply(op, a, b);
            ex = ref_alu(op, a, b);
            check_all(op, ex[W-1:0], ex[W]);
        end

        // R2: a new input does not show until the next rising edge.
        apply(4'b0010, 32'd10, 32'd20);
        @(negedge clk);
        op_i = 4'b0000; a_i = 32'h0; b_i = 32'h0;
        #1;
        check("R2", "held before edge", result_o, 32'd30);
        @(negedge clk);
        check("R2", "updated after edge", result_o, 32'd0);

        // R1: synchronous reset clears a nonzero result with ovf set.
        apply(4'b0010, 32'h8000_0000, 32'h8000_0001);
        check("R3", "ovf before reset", {31'b0, ovf_o}, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "mid reset result", result_o, '0);
        check("R1", "mid reset ovf", {31'b0, ovf_o}, 32'h0);
        check("R1", "mid reset zero", {31'b0, zero_o}, 32'h1);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule